// File: doc/BRIEF.md
# Issue Queue Split Reconfiguration Controller

This controller decides how a fixed array of issue queue entries is divided into in-order FIFOs. The array never changes size. Only the split changes: at level L there are `ENTRIES >> L` FIFOs, each `1 << L` entries deep. Level 0 is the widest split, with one entry per FIFO. The deepest level is a single FIFO that covers the whole array.

At the end of every statistics window, the surrounding pipeline pulses `win_done`. On that pulse it presents the window's totals: instructions issued, instructions committed, ready instructions, ready instructions that stalled, current and average queue occupancy, and a running average issue rate. The controller converts the counts to rates in hundredths of an instruction per cycle. It remembers the rate of the previous window and the rate of the last window spent at level 0. From these it moves one level toward more, shallower FIFOs, one level toward fewer, deeper FIFOs, or holds.

The controller also produces one arbiter enable bit per entry. Each FIFO keeps its oldest instruction at the lowest index of its segment. Only a valid entry at a segment base may request issue. The enables follow the level register combinationally, so a new split takes effect with no lost cycles.

Top module: `fifo_split_ctrl`

## Requirements
- R1: After reset the level is 0, `fifo_count` is 64 and `fifo_depth` is 1, and neither the previous-window rate nor the level-0 rate is known.
- R2: The level changes only in the clock edge that samples `win_done` high, by exactly one step, and saturates at 0 and at 6. On every other edge it holds.
- R3: A window rate is floor(count * 100 / 1024) in hundredths of an instruction per cycle. This applies to both the issue count and the commit count.
- R4: The level rises (FIFO count halves) when the issue rate exceeds the commit rate by more than 100.
- R5: The level rises when stall*100 < 3*ready, where stall and ready are the window's stalled-ready and ready counts.
- R6: The level rises when the issue rate is below 270 - 20*L, where L is the level during the window.
- R7: The level rises when occ_cur*100 < 20*occ_avg.
- R8: The level rises when avg_ipc - issue rate > 15 + 15*L.
- R9: The level falls (FIFO count doubles) when a previous window exists since reset and 100*rate < 92*previous rate, which is a drop of more than 8%.
- R10: The level falls when a window at level 0 has been seen since reset and 100*rate < 94*rate of the most recent level-0 window, which is a drop of more than 6%.
- R11: The level falls when stall*100 > 15*ready.
- R12: A fall condition beats every rise condition. At level 0, a fall condition holds the level rather than letting a rise happen.
- R13: `fifo_count` = 64 >> L and `fifo_depth` = 1 << L. `head_en[i]` = `ent_valid[i]` and (i mod `fifo_depth`) == 0, following the level with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_done | input | 1 | One-cycle pulse at the end of a statistics window |
| issue_cnt | input | 13 | Instructions issued during the window |
| commit_cnt | input | 13 | Instructions committed during the window |
| ready_cnt | input | 16 | Ready instructions seen during the window |
| stall_cnt | input | 16 | Ready instructions that stalled during the window |
| occ_cur | input | 7 | Current queue occupancy |
| occ_avg | input | 7 | Average queue occupancy |
| avg_ipc | input | 12 | Running average issue rate, hundredths |
| ent_valid | input | 64 | Valid bit of each queue entry |
| level | output | 3 | Current split level L |
| fifo_count | output | 7 | Number of FIFOs at the current level |
| fifo_depth | output | 7 | Entries per FIFO at the current level |
| head_en | output | 64 | Arbiter enable per entry |

## Verification
Each rise trigger is tested alone, straddling its threshold: stall at exactly 3%, occupancy at exactly 20%, drift at exactly the level-scaled limit, and an issue count that rounds to 270 versus 269. A design that uses `<=` or the wrong rounding moves one window too early. The two fall triggers are separated by sequences in which only the previous-window rate or only the level-0 rate shows the drop, so a design that mixes up the two histories, or updates the level-0 rate at other levels, gives the wrong level. Priority is tested with rise and fall triggers present together, both above level 0 and at level 0, and repeated rises test saturation at 6. Random windows then compare every level and every enable bit against a bench model.

// File: rtl/fq_cfg_pkg.sv
// Package: thresholds and shared types of the FIFO split controller.
// Rates are in hundredths of an instruction per cycle. Percent values are whole percents.
package fq_cfg_pkg;
    localparam int RATE_ONE      = 100; // one instruction per cycle
    localparam int SH_GAP        = 100; // issue minus commit limit
    localparam int SH_STALL_PCT  = 3;   // low-stall limit
    localparam int SH_IPC_BASE   = 270; // low-rate limit at level 0
    localparam int SH_IPC_STEP   = 20;  // low-rate limit drop per level
    localparam int SH_OCC_PCT    = 20;  // occupancy fraction of average
    localparam int SH_DRIFT_BASE = 15;  // drift limit at level 0
    localparam int SH_DRIFT_STEP = 15;  // drift limit rise per level
    localparam int GR_PREV_KEEP  = 92;  // kept share of previous rate
    localparam int GR_FPM_KEEP   = 94;  // kept share of level-0 rate
    localparam int GR_STALL_PCT  = 15;  // high-stall limit

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_GROW   = 2'd1,  // more, shallower FIFOs (level down)
        ACT_SHRINK = 2'd2   // fewer, deeper FIFOs (level up)
    } fq_act_e;
endpackage

// File: rtl/fq_rate.sv
// fq_rate: converts a per-window count into a rate in hundredths.
// Assumes the window length is 2**WIN_LG cycles and the result fits RATE_W bits.
module fq_rate #(
    parameter int CNT_W  = 13,
    parameter int WIN_LG = 10,
    parameter int RATE_W = 12
) (
    input  logic [CNT_W-1:0]  cnt,
    output logic [RATE_W-1:0] rate
);
    import fq_cfg_pkg::*;

    logic [31:0] scaled;

    // Scale to hundredths, then divide by the window length.
    always_comb begin
        scaled = 32'(cnt) * 32'(RATE_ONE);
        rate   = RATE_W'(scaled >> WIN_LG);
    end
endmodule

// File: rtl/fq_decide.sv
// fq_decide: combinational policy. Evaluates the fall (grow) and rise (shrink)
// triggers for one window. A fall trigger masks every rise trigger.
// Assumes the history inputs are only meaningful when their valid bits are set.
module fq_decide #(
    parameter int RATE_W = 12,
    parameter int STAT_W = 16,
    parameter int OCC_W  = 7,
    parameter int LVL_W  = 3
) (
    input  logic [RATE_W-1:0] ipc_now,
    input  logic [RATE_W-1:0] ipc_cmt,
    input  logic [RATE_W-1:0] avg_ipc,
    input  logic [RATE_W-1:0] prev_ipc,
    input  logic              prev_v,
    input  logic [RATE_W-1:0] fpm_ipc,
    input  logic              fpm_v,
    input  logic [STAT_W-1:0] ready_cnt,
    input  logic [STAT_W-1:0] stall_cnt,
    input  logic [OCC_W-1:0]  occ_cur,
    input  logic [OCC_W-1:0]  occ_avg,
    input  logic [LVL_W-1:0]  level,
    output fq_cfg_pkg::fq_act_e act
);
    import fq_cfg_pkg::*;

    logic [31:0] now_w, cmt_w, avg_w, rdy_w, stl_w, lvl_w;
    logic [31:0] ipc_floor, drift_lim, low_step;
    logic        gr_prev, gr_fpm, gr_stall, grow_any;
    logic        sh_gap, sh_stall, sh_ipc, sh_occ, sh_drift, shrink_any;

    // Widen the operands once so every comparison is done in 32 bits.
    always_comb begin
        now_w = 32'(ipc_now);
        cmt_w = 32'(ipc_cmt);
        avg_w = 32'(avg_ipc);
        rdy_w = 32'(ready_cnt);
        stl_w = 32'(stall_cnt);
        lvl_w = 32'(level);
    end

    // Level-scaled limits. The low-rate floor clamps at zero.
    always_comb begin
        low_step  = lvl_w * 32'(SH_IPC_STEP);
        ipc_floor = (32'(SH_IPC_BASE) > low_step) ? 32'(SH_IPC_BASE) - low_step : 32'd0;
        drift_lim = 32'(SH_DRIFT_BASE) + lvl_w * 32'(SH_DRIFT_STEP);
    end

    // Fall triggers: the rate drops against either history, or too many stalls.
    always_comb begin
        gr_prev  = prev_v && (now_w * 32'(RATE_ONE) < 32'(prev_ipc) * 32'(GR_PREV_KEEP));
        gr_fpm   = fpm_v  && (now_w * 32'(RATE_ONE) < 32'(fpm_ipc)  * 32'(GR_FPM_KEEP));
        gr_stall = stl_w * 32'(RATE_ONE) > rdy_w * 32'(GR_STALL_PCT);
        grow_any = gr_prev || gr_fpm || gr_stall;
    end

    // Rise triggers: throughput or occupancy suggests the wide split is not needed.
    always_comb begin
        sh_gap     = now_w > cmt_w + 32'(SH_GAP);
        sh_stall   = stl_w * 32'(RATE_ONE) < rdy_w * 32'(SH_STALL_PCT);
        sh_ipc     = now_w < ipc_floor;
        sh_occ     = 32'(occ_cur) * 32'(RATE_ONE) < 32'(occ_avg) * 32'(SH_OCC_PCT);
        sh_drift   = avg_w > now_w + drift_lim;
        shrink_any = sh_gap || sh_stall || sh_ipc || sh_occ || sh_drift;
    end

    // Priority encode: fall first, then rise, else hold.
    always_comb begin
        if (grow_any)        act = ACT_GROW;
        else if (shrink_any) act = ACT_SHRINK;
        else                 act = ACT_HOLD;
    end
endmodule

// File: rtl/fq_head_map.sv
// fq_head_map: maps the current split onto the fixed entry array.
// Assumes each FIFO keeps its oldest entry at the lowest index of its segment,
// so a segment base with a valid entry is the only one that may request issue.
module fq_head_map #(
    parameter int ENTRIES = 64,
    parameter int LVL_W   = 3,
    parameter int OCC_W   = 7
) (
    input  logic [LVL_W-1:0]   level,
    input  logic [ENTRIES-1:0] ent_valid,
    output logic [OCC_W-1:0]   fifo_count,
    output logic [OCC_W-1:0]   fifo_depth,
    output logic [ENTRIES-1:0] head_en
);
    logic [31:0] seg_mask;

    // Segment geometry for the current level.
    always_comb begin
        fifo_count = OCC_W'(32'(ENTRIES) >> level);
        fifo_depth = OCC_W'(32'd1 << level);
        seg_mask   = (32'd1 << level) - 32'd1;
    end

    // One enable per entry: valid and at the base of its segment.
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_head
        assign head_en[gi] = ent_valid[gi] && ((32'(gi) & seg_mask) == 32'd0);
    end
endmodule

// File: rtl/fifo_split_ctrl.sv
// fifo_split_ctrl: top of the issue queue split controller.
// Holds the split level and the rate history. Steps the level once per window.
// Assumes win_done is a single-cycle pulse with the window statistics valid alongside it.
module fifo_split_ctrl #(
    parameter int ENTRIES = 64,
    parameter int WIN_LG  = 10,
    parameter int CNT_W   = 13,
    parameter int STAT_W  = 16,
    parameter int RATE_W  = 12,
    localparam int LVL_MAX = $clog2(ENTRIES),
    localparam int LVL_W   = $clog2(LVL_MAX + 1),
    localparam int OCC_W   = $clog2(ENTRIES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_done,
    input  logic [CNT_W-1:0]   issue_cnt,
    input  logic [CNT_W-1:0]   commit_cnt,
    input  logic [STAT_W-1:0]  ready_cnt,
    input  logic [STAT_W-1:0]  stall_cnt,
    input  logic [OCC_W-1:0]   occ_cur,
    input  logic [OCC_W-1:0]   occ_avg,
    input  logic [RATE_W-1:0]  avg_ipc,
    input  logic [ENTRIES-1:0] ent_valid,
    output logic [LVL_W-1:0]   level,
    output logic [OCC_W-1:0]   fifo_count,
    output logic [OCC_W-1:0]   fifo_depth,
    output logic [ENTRIES-1:0] head_en
);
    import fq_cfg_pkg::*;

    logic [RATE_W-1:0] ipc_now, ipc_cmt;
    logic [RATE_W-1:0] prev_ipc, fpm_ipc;
    logic              prev_v, fpm_v;
    fq_act_e           act;

    fq_rate #(.CNT_W(CNT_W), .WIN_LG(WIN_LG), .RATE_W(RATE_W)) u_rate_iss (
        .cnt(issue_cnt), .rate(ipc_now));

    fq_rate #(.CNT_W(CNT_W), .WIN_LG(WIN_LG), .RATE_W(RATE_W)) u_rate_cmt (
        .cnt(commit_cnt), .rate(ipc_cmt));

    fq_decide #(.RATE_W(RATE_W), .STAT_W(STAT_W), .OCC_W(OCC_W), .LVL_W(LVL_W)) u_decide (
        .ipc_now(ipc_now), .ipc_cmt(ipc_cmt), .avg_ipc(avg_ipc),
        .prev_ipc(prev_ipc), .prev_v(prev_v), .fpm_ipc(fpm_ipc), .fpm_v(fpm_v),
        .ready_cnt(ready_cnt), .stall_cnt(stall_cnt),
        .occ_cur(occ_cur), .occ_avg(occ_avg), .level(level), .act(act));

    fq_head_map #(.ENTRIES(ENTRIES), .LVL_W(LVL_W), .OCC_W(OCC_W)) u_head (
        .level(level), .ent_valid(ent_valid),
        .fifo_count(fifo_count), .fifo_depth(fifo_depth), .head_en(head_en));

    // Level register: one saturating step per window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (win_done) begin
            if (act == ACT_GROW && level != '0)
                level <= level - 1'b1;
            else if (act == ACT_SHRINK && level != LVL_W'(LVL_MAX))
                level <= level + 1'b1;
        end
    end

    // Rate history: previous window always, level-0 window only at level 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ipc <= '0;
            prev_v   <= 1'b0;
            fpm_ipc  <= '0;
            fpm_v    <= 1'b0;
        end else if (win_done) begin
            prev_ipc <= ipc_now;
            prev_v   <= 1'b1;
            if (level == '0) begin
                fpm_ipc <= ipc_now;
                fpm_v   <= 1'b1;
            end
        end
    end

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(LVL_MAX)); // R2
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |=> $stable(level)); // R2
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> (level == $past(level) || level == $past(level) + 1'b1
                      || $past(level) == level + 1'b1)); // R2
    AST_GROW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && act == ACT_GROW && level != '0) |=> level + 1'b1 == $past(level)); // R12
    AST_HEAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (head_en & ~ent_valid) == '0); // R13
    AST_HEAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(head_en) <= int'(fifo_count)); // R13
endmodule

// File: tb/sim_fifo_split_ctrl.sv
module sim_fifo_split_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_done = 1'b0;
    logic [12:0] issue_cnt = '0, commit_cnt = '0;
    logic [15:0] ready_cnt = '0, stall_cnt = '0;
    logic [6:0]  occ_cur = '0, occ_avg = '0;
    logic [11:0] avg_ipc = '0;
    logic [63:0] ent_valid = '0;
    logic [2:0]  level;
    logic [6:0]  fifo_count, fifo_depth;
    logic [63:0] head_en;

    int checks = 0;
    int errors = 0;
    int m_lvl, m_prev, m_fpm;
    bit m_pv, m_fv;

    fifo_split_ctrl u0 (.*);

    always #10 clk = ~clk; // 50 MHz

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rate(int c);
        return (c * 100) / 1024;
    endfunction

    // Checks the outputs against the model level (R13, R1 shape).
    task automatic chk_outputs(string req);
        logic [63:0] exp_h;
        for (int i = 0; i < 64; i++)
            exp_h[i] = ent_valid[i] && ((i % (1 << m_lvl)) == 0);
        chk(level == 3'(m_lvl), req, level, m_lvl);
        chk(fifo_count == 7'(64 >> m_lvl), "R13 count", fifo_count, 64 >> m_lvl);
        chk(fifo_depth == 7'(1 << m_lvl), "R13 depth", fifo_depth, 1 << m_lvl);
        chk(head_en == exp_h, "R13 heads", head_en, exp_h);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        m_lvl = 0; m_prev = 0; m_fpm = 0; m_pv = 0; m_fv = 0;
    endtask

    // Drives one window end and updates the model.
    task automatic win(int iss, int cmt, int rdy, int stl, int oc, int oa, int av, string req);
        int ip, cp, thr, dl;
        bit g, s;
        @(negedge clk);
        issue_cnt = 13'(iss); commit_cnt = 13'(cmt);
        ready_cnt = 16'(rdy); stall_cnt = 16'(stl);
        occ_cur = 7'(oc); occ_avg = 7'(oa); avg_ipc = 12'(av);
        ent_valid = {$urandom, $urandom};
        win_done = 1'b1;
        ip = rate(iss); cp = rate(cmt);
        thr = (270 > 20 * m_lvl) ? 270 - 20 * m_lvl : 0;
        dl = 15 + 15 * m_lvl;
        g = (m_pv && ip * 100 < m_prev * 92) || (m_fv && ip * 100 < m_fpm * 94)
            || (stl * 100 > rdy * 15);
        s = (ip > cp + 100) || (stl * 100 < rdy * 3) || (ip < thr)
            || (oc * 100 < oa * 20) || (av > ip + dl);
        m_prev = ip; m_pv = 1;
        if (m_lvl == 0) begin m_fpm = ip; m_fv = 1; end
        if (g) begin if (m_lvl > 0) m_lvl--; end
        else if (s) begin if (m_lvl < 6) m_lvl++; end
        @(negedge clk);
        win_done = 1'b0;
        chk_outputs(req);
    endtask

    // Neutral window at rate 283: triggers nothing.
    task automatic neutral(string req);
        win(2900, 2900, 100, 10, 30, 40, 283, req);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        @(negedge clk);
        chk_outputs("R1 reset");
        neutral("R1 neutral holds");

        do_reset(); win(2900, 1700, 100, 10, 30, 40, 283, "R4 gap");
        chk(level == 3'd1, "R4", level, 1);
        do_reset(); win(2900, 1900, 100, 10, 30, 40, 283, "R4 gap edge");
        do_reset(); win(2900, 2900, 100, 3, 30, 40, 283, "R5 stall 3pct holds");
        do_reset(); win(2900, 2900, 100, 2, 30, 40, 283, "R5 stall below 3pct");
        do_reset(); win(2765, 2765, 100, 10, 30, 40, 270, "R3 R6 rate 270 holds");
        do_reset(); win(2764, 2764, 100, 10, 30, 40, 269, "R3 R6 rate 269 rises");
        do_reset(); win(2900, 2900, 100, 10, 8, 40, 283, "R7 occ 20pct holds");
        do_reset(); win(2900, 2900, 100, 10, 7, 40, 283, "R7 occ below 20pct");
        do_reset(); win(2900, 2900, 100, 10, 30, 40, 298, "R8 drift edge holds");
        do_reset(); win(2900, 2900, 100, 10, 30, 40, 299, "R8 drift rises");
        // R8 level scaling: at level 1 the limit is 30
        win(2900, 2900, 100, 10, 30, 40, 313, "R8 level1 holds");
        win(2900, 2900, 100, 10, 30, 40, 314, "R8 level1 rises");

        // R11 stall fall, with boundary
        do_reset(); win(2900, 1700, 100, 10, 30, 40, 283, "R11 setup");
        win(2900, 2900, 100, 15, 30, 40, 283, "R11 stall 15pct holds");
        win(2900, 2900, 100, 16, 30, 40, 283, "R11 stall falls");

        // R10 only: drop against the level-0 window, not the previous one
        do_reset(); neutral("R10 setup"); win(2900, 1700, 100, 10, 30, 40, 283, "R10 setup");
        win(2724, 2724, 100, 10, 30, 40, 266, "R10 level0 drop");
        chk(level == 3'd0, "R10", level, 0);

        // R9 only: drop against the previous window, level-0 rate low
        do_reset(); win(2048, 2048, 100, 10, 30, 40, 200, "R9 setup");
        win(2900, 2900, 100, 10, 30, 40, 283, "R9 setup");
        win(2663, 2663, 100, 10, 30, 40, 260, "R9 previous drop");
        chk(level == 3'd0, "R9", level, 0);

        // R12 priority above and at level 0
        do_reset(); win(2900, 1700, 100, 10, 30, 40, 283, "R12 setup");
        win(2900, 1700, 100, 20, 30, 40, 283, "R12 fall beats rise");
        win(2900, 1700, 100, 20, 30, 40, 283, "R12 hold at level 0");

        // R2 saturation at the deep end
        do_reset();
        for (int k = 0; k < 8; k++) win(2900, 1700, 100, 10, 30, 40, 283, "R2 saturate");
        chk(level == 3'd6, "R2 max", level, 6);

        // R2: no change without win_done
        @(negedge clk); issue_cnt = 13'd0; ready_cnt = 16'd100; stall_cnt = 16'd90;
        repeat (3) @(negedge clk);
        chk_outputs("R2 idle hold");

        // Random windows against the model
        do_reset();
        for (int k = 0; k < 400; k++) begin
            int iss, cmt, rdy, ip;
            iss = 1500 + int'($urandom_range(1700));
            cmt = iss - int'($urandom_range(1300));
            rdy = 50 + int'($urandom_range(150));
            ip = rate(iss);
            win(iss, cmt, rdy, int'($urandom_range(rdy * 3 / 10)),
                int'($urandom_range(64)), int'($urandom_range(64)),
                ip + int'($urandom_range(60)) - 30 < 0 ? 0 : ip + int'($urandom_range(60)) - 30,
                "R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule